// File: doc/BRIEF.md
# Reference Divider with Polarity-Selectable Phase-Frequency Detector

This block is the reference half of a frequency synthesizer loop. It takes a stream of single-cycle reference ticks, counts them down by a programmable 15-bit ratio, and emits one comparison pulse every ratio-th tick. If the reference ticks arrive at 4 MHz and the ratio is 64, comparison pulses come at 62.5 kHz. A ratio of 16 gives 250 kHz. Each comparison pulse goes into a three-state phase-frequency detector, where it is weighed against a feedback tick coming from the loop's main divider. The detector's two outputs command the charge pump to source or sink current.

A new ratio is only adopted at the end of a divide period, so a period that has already started always runs to completion. A ratio of 0, 1 or 2 is not a legal value. When one is presented, the divider keeps the last legal ratio it adopted. A polarity input exchanges the two detector outputs, which lets the same loop suit a VCO whose frequency rises with tuning voltage as well as one whose frequency falls. A group of reserved mode bits has no effect on the block's behaviour. If any of them is set, a flag is raised.

Top module: `refdiv_pfd_top`

## Requirements
- R1: While reset is held (active-low `rstN` = 0), `cmpTick`, `chargeUp` and `chargeDown` are all 0.
- R2: `cmpTick` is a one-cycle pulse. It goes high in the cycle after the clock edge that samples the ratio-th `refTick` of a period. Cycles in which `refTick` is low do not advance the count.
- R3: `divRatio` is sampled only at the terminal tick of a period. A change made during a period does not alter that period's length. The new value governs the next period.
- R4: A `divRatio` value of 0, 1 or 2 is ignored at the terminal tick, and the previously adopted ratio stays in force. After reset the adopted ratio is 3.
- R5: The full range 3 to 32767 is honoured, including the maximum of 32767 ticks per period.
- R6: A comparison pulse sets the reference-side detector state in the next cycle. A `fbTick` sets the feedback-side state in the next cycle. Once both states are set, both clear one cycle later.
- R7: With `polarity` = 0, `chargeUp` carries the reference-side state and `chargeDown` carries the feedback-side state. With `polarity` = 1 the two outputs are exchanged. The exchange takes effect in the same cycle that `polarity` changes.
- R8: `rsvdFlag` is 1 exactly when any bit of `modeRsvd` is 1. The `modeRsvd` bits have no effect on `cmpTick`, `chargeUp` or `chargeDown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | Reference event, one cycle per reference period |
| fbTick | input | 1 | Feedback event from the main divider |
| divRatio | input | 15 | Requested divide ratio; legal values are 3 to 32767 |
| polarity | input | 1 | 0 = positive-slope VCO, 1 = negative-slope VCO (outputs exchanged) |
| modeRsvd | input | 4 | Reserved mode bits, expected to be 0 |
| cmpTick | output | 1 | Divided-reference comparison pulse |
| chargeUp | output | 1 | Charge pump source command |
| chargeDown | output | 1 | Charge pump sink command |
| rsvdFlag | output | 1 | High when any reserved mode bit is set |

## Verification
The assertions check four properties on every cycle:
- The comparison pulse never lasts two cycles.
- No pulse follows a cycle without a reference tick.
- Every comparison or feedback event makes a detector output rise in the next cycle.
- Two detector outputs that are both high, with no new event arriving, clear on the next edge.

Other behaviours can only be shown by the bench's scenarios, which count divide periods in ticks across a sweep of ratios:
- the exact period length,
- the deferred adoption of a new ratio,
- the holding of a legal ratio against values of 0 to 2,
- the 32767 maximum,
- which output leads under each polarity setting.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // Smallest divide ratio the divider accepts.
  localparam int unsigned MIN_RATIO = 3;

  // Strobes passed from the counting control to the datapath.
  typedef struct packed {
    logic wrap;       // terminal reference tick of the current period
    logic takeRatio;  // wrap with a legal requested ratio
  } divStrobe_t;

endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic [RATIO_W-1:0] activeRatio,
  input  logic [RATIO_W-1:0] ratioIn,
  output divStrobe_t         strb
);

  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] ONE   = RATIO_W'(1);

  logic [RATIO_W-1:0] tickCount;
  logic [RATIO_W-1:0] lastIdx;
  logic               atLast;
  logic               ratioLegal;

  // The period ends on tick number activeRatio, which is index activeRatio-1.
  assign lastIdx    = activeRatio - ONE;
  assign atLast     = (tickCount >= lastIdx);
  assign ratioLegal = (ratioIn >= MIN_R);

  always_comb begin
    strb           = '0;
    strb.wrap      = refTick && atLast;
    strb.takeRatio = refTick && atLast && ratioLegal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (refTick) begin
      if (atLast) tickCount <= '0;
      else        tickCount <= tickCount + ONE;
    end
  end

endmodule

// File: rtl/refdiv_dp.sv
module refdiv_dp
  import refdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strb,
  input  logic [RATIO_W-1:0] ratioIn,
  input  logic               fbTick,
  input  logic               polarity,
  output logic [RATIO_W-1:0] activeRatio,
  output logic               cmpTick,
  output logic               chargeUp,
  output logic               chargeDown
);

  localparam logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(MIN_RATIO);

  logic refSide;
  logic fbSide;
  logic bothSet;
  logic refSideNext;
  logic fbSideNext;

  // The adopted ratio only moves at a terminal tick, and only to a legal value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeRatio <= RESET_RATIO;
    end else if (strb.takeRatio) begin
      activeRatio <= ratioIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpTick <= 1'b0;
    else       cmpTick <= strb.wrap;
  end

  // Three-state detector. When both sides are set, both clear. Events that
  // arrive during that clearing cycle start the next comparison.
  assign bothSet = refSide && fbSide;

  always_comb begin
    if (bothSet) begin
      refSideNext = cmpTick;
      fbSideNext  = fbTick;
    end else begin
      refSideNext = refSide || cmpTick;
      fbSideNext  = fbSide  || fbTick;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSide <= 1'b0;
      fbSide  <= 1'b0;
    end else begin
      refSide <= refSideNext;
      fbSide  <= fbSideNext;
    end
  end

  // The polarity bit picks which side drives the source command.
  always_comb begin
    if (polarity) begin
      chargeUp   = fbSide;
      chargeDown = refSide;
    end else begin
      chargeUp   = refSide;
      chargeDown = fbSide;
    end
  end

endmodule

// File: rtl/refdiv_pfd_top.sv
module refdiv_pfd_top
  import refdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 15,
  parameter int unsigned RSVD_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic               fbTick,
  input  logic [RATIO_W-1:0] divRatio,
  input  logic               polarity,
  input  logic [RSVD_W-1:0]  modeRsvd,
  output logic               cmpTick,
  output logic               chargeUp,
  output logic               chargeDown,
  output logic               rsvdFlag
);

  divStrobe_t         strb;
  logic [RATIO_W-1:0] activeRatio;

  refdiv_ctrl #(.RATIO_W(RATIO_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .refTick    (refTick),
    .activeRatio(activeRatio),
    .ratioIn    (divRatio),
    .strb       (strb)
  );

  refdiv_dp #(.RATIO_W(RATIO_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ratioIn    (divRatio),
    .fbTick     (fbTick),
    .polarity   (polarity),
    .activeRatio(activeRatio),
    .cmpTick    (cmpTick),
    .chargeUp   (chargeUp),
    .chargeDown (chargeDown)
  );

  // The reserved bits feed nothing but this flag.
  assign rsvdFlag = |modeRsvd;

endmodule

// File: rtl/refdiv_pfd_checker.sv
module refdiv_pfd_checker (
  input logic clk,
  input logic rstN,
  input logic refTick,
  input logic fbTick,
  input logic cmpTick,
  input logic chargeUp,
  input logic chargeDown
);

  // R2: the comparison pulse lasts exactly one cycle.
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmpTick |=> !cmpTick);

  // R2: no reference tick means no comparison pulse in the next cycle.
  p_idle_no_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> !cmpTick);

  // R6: a comparison pulse sets a detector output in the next cycle.
  p_cmp_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmpTick && !(chargeUp && chargeDown)) |=> (chargeUp || chargeDown));

  // R6: a feedback tick sets a detector output in the next cycle.
  p_fb_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fbTick && !(chargeUp && chargeDown)) |=> (chargeUp || chargeDown));

  // R6: both outputs high with no new event means both clear next cycle.
  p_both_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (chargeUp && chargeDown && !cmpTick && !fbTick) |=> (!chargeUp && !chargeDown));

endmodule

bind refdiv_pfd_top refdiv_pfd_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .refTick   (refTick),
  .fbTick    (fbTick),
  .cmpTick   (cmpTick),
  .chargeUp  (chargeUp),
  .chargeDown(chargeDown)
);

// File: tb/refdiv_pfd_top_tb_top.sv
`timescale 1ns/1ps
module refdiv_pfd_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        fbTick = 1'b0;
  logic [14:0] divRatio = 15'd7;
  logic        polarity = 1'b0;
  logic [3:0]  modeRsvd = 4'd0;
  logic        cmpTick, chargeUp, chargeDown, rsvdFlag;

  int vectors = 0;
  int fails = 0;
  int expActive = 3;
  bit done = 0;

  always #5 clk = ~clk;

  refdiv_pfd_top dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .fbTick(fbTick),
    .divRatio(divRatio), .polarity(polarity), .modeRsvd(modeRsvd),
    .cmpTick(cmpTick), .chargeUp(chargeUp), .chargeDown(chargeDown),
    .rsvdFlag(rsvdFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs are applied just after a falling edge; the next rising edge samples
  // them and the following falling edge is where results are checked.
  task automatic stepCycle(input logic rt, input logic fb);
    refTick = rt;
    fbTick  = fb;
    @(negedge clk);
    refTick = 1'b0;
    fbTick  = 1'b0;
  endtask

  // One divide period of len ticks, with gap idle cycles after each tick.
  // The requested ratio is changed on the first tick of the period.
  task automatic runPeriod(input int len, input int gap, input int newRatio);
    for (int i = 1; i <= len; i++) begin
      if (i == 1) divRatio = 15'(newRatio);
      modeRsvd = 4'(i * 7 + len);
      stepCycle(1'b1, 1'b0);
      check("R2 R3 R8 pulse on terminal tick", cmpTick, (i == len) ? 1 : 0);
      check("R8 reserved flag", rsvdFlag, (modeRsvd != 4'd0) ? 1 : 0);
      for (int g = 0; g < gap; g++) begin
        stepCycle(1'b0, 1'b0);
        check("R2 no count without tick", cmpTick, 0);
      end
    end
    modeRsvd = 4'd0;
    if (newRatio >= 3) expActive = newRatio;
  endtask

  // Clears the reference-side state left over from the divide periods.
  task automatic clearPfd();
    stepCycle(1'b0, 1'b1);
    stepCycle(1'b0, 1'b0);
    check("R6 detector idle", {chargeUp, chargeDown}, 0);
  endtask

  task automatic pfdRefFirst(input logic pol);
    polarity = pol;
    for (int i = 1; i <= 3; i++) stepCycle(1'b1, 1'b0);
    check("R2 pulse before detector", cmpTick, 1);
    stepCycle(1'b0, 1'b0);
    check("R6 R7 ref side leads", pol ? chargeDown : chargeUp, 1);
    check("R6 R7 fb side idle", pol ? chargeUp : chargeDown, 0);
    polarity = ~pol;
    #1;
    check("R7 live swap lead", pol ? chargeUp : chargeDown, 1);
    check("R7 live swap other", pol ? chargeDown : chargeUp, 0);
    polarity = pol;
    @(negedge clk);
    stepCycle(1'b0, 1'b1);
    check("R6 both set", {chargeUp, chargeDown}, 3);
    stepCycle(1'b0, 1'b0);
    check("R6 both cleared", {chargeUp, chargeDown}, 0);
  endtask

  task automatic pfdFbFirst(input logic pol);
    polarity = pol;
    stepCycle(1'b0, 1'b1);
    check("R6 R7 fb side set", pol ? chargeUp : chargeDown, 1);
    check("R6 R7 ref side idle", pol ? chargeDown : chargeUp, 0);
    for (int i = 1; i <= 3; i++) begin
      stepCycle(1'b1, 1'b0);
      check("R6 fb side held", pol ? chargeUp : chargeDown, 1);
    end
    stepCycle(1'b0, 1'b0);
    check("R6 both set after ref", {chargeUp, chargeDown}, 3);
    stepCycle(1'b0, 1'b0);
    check("R6 both cleared", {chargeUp, chargeDown}, 0);
  endtask

  task automatic pfdSame();
    for (int i = 1; i <= 3; i++) stepCycle(1'b1, 1'b0);
    stepCycle(1'b0, 1'b1);
    check("R6 coincident events set both", {chargeUp, chargeDown}, 3);
    stepCycle(1'b0, 1'b0);
    check("R6 coincident cleared", {chargeUp, chargeDown}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cmpTick", cmpTick, 0);
    check("R1 reset outputs", {chargeUp, chargeDown}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: the first period after reset uses the reset ratio of 3.
    runPeriod(3, 0, 7);
    // R3: each period keeps the previous ratio while the new one waits.
    for (int r = 3; r <= 24; r++) runPeriod(expActive, r % 3, r);
    runPeriod(expActive, 1, 5);
    // R4: illegal ratios 0, 1, 2 are held off.
    runPeriod(expActive, 0, 0);
    runPeriod(expActive, 2, 1);
    runPeriod(expActive, 0, 2);
    check("R4 legal ratio retained", expActive, 5);
    runPeriod(expActive, 0, 32767);
    // R5: the maximum ratio.
    runPeriod(32767, 0, 3);
    runPeriod(expActive, 0, 3);

    clearPfd();
    pfdRefFirst(1'b0);
    pfdRefFirst(1'b1);
    pfdFbFirst(1'b0);
    pfdFbFirst(1'b1);
    polarity = 1'b0;
    pfdSame();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0 (run did not complete)");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule